// File: doc/BRIEF.md
# DRAM Command Steering Stage

This block sits between a set of bank machines and a multi-phase DRAM PHY. Each bank machine offers one pending command at a time through a valid/ready handshake. The block chooses which offers go out in the current controller cycle. In a frequency-ratio system one controller cycle covers several DRAM command slots, so up to `NPHASE` commands from different banks can leave together, one per phase slot.

Column traffic is batched by direction. The block keeps a current direction, read or write, and grants column commands of that direction only. It turns the bus around when nothing of the current direction is waiting, or when a run limit has been reached and the other direction is waiting. Timers hold off reads after a write (write-to-read) and writes after a read (read-to-write turnaround), so the shared data bus never carries both at once. Row commands (precharge, activate) are granted independently of the direction.

Each bank presents only the head of its own queue. Commands within a bank therefore keep their order, and the block only interleaves commands from different banks.

Top module: `dram_cmd_steer`

## Requirements
- R1: `req_ready[i]` is high only while `req_valid[i]` is high. No more than `NPHASE` banks are granted in one cycle, and each bank gets at most one grant per cycle.
- R2: Each cycle, banks are scanned in round-robin order starting at a pointer. Eligible banks fill the slots in scan order. After any grant, the pointer moves to the bank just after the last one granted.
- R3: The command code is 2 bits per bank: 0 precharge, 1 activate, 2 read, 3 write. A read or write is granted only when its bit 0 equals the current direction (0 = read, 1 = write), so one cycle's grants never mix reads and writes.
- R4: When no request of the current direction is pending and one of the other direction is, the direction flips at the end of that cycle. No column command is granted in that cycle.
- R5: After `MAX_RUN` cycles that granted column commands in the current direction, no further column command of that direction is granted while the other direction is waiting, and the direction flips.
- R6: A read is granted no earlier than `T_WTR`+1 cycles after the last cycle that granted a write.
- R7: A write is granted no earlier than `T_RTW`+1 cycles after the last cycle that granted a read.
- R8: At most one row command (precharge or activate) is granted per cycle. Row commands do not depend on the direction or the timers.
- R9: Commands granted in a cycle appear on the phase outputs one cycle later, in scan order from slot 0. Each slot carries a valid bit, the command code, the bank index and the address. An unused slot has valid 0 and command 0.
- R10: After reset the direction is read, the pointer is at bank 0, all timers and the run count are zero, and all slot valid bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NBANK | Bank i has a pending command |
| req_ready | output | NBANK | Bank i's command is granted this cycle |
| req_cmd | input | 2*NBANK | Command code per bank |
| req_addr | input | AW*NBANK | Address per bank |
| ph_valid | output | NPHASE | Slot carries a command |
| ph_cmd | output | 2*NPHASE | Command code per slot |
| ph_bank | output | BW*NPHASE | Bank index per slot |
| ph_addr | output | AW*NPHASE | Address per slot |

## Verification
Grants on `req_ready` are combinational. The bench drives requests just after the falling edge and reads the ready mask 1 ns later, in the same cycle. The phase slots are due one rising edge after the grant, so they are sampled at the following falling edge. Turnaround and run-length tests count cycles from a known reset state. Each expected blocked or granted cycle is checked at the exact cycle offset given by `T_WTR`, `T_RTW` and `MAX_RUN`.

// File: rtl/dram_cmd_steer.sv
module dram_cmd_steer #(
  parameter int NBANK   = 4,
  parameter int NPHASE  = 2,
  parameter int AW      = 8,
  parameter int T_WTR   = 3,
  parameter int T_RTW   = 2,
  parameter int MAX_RUN = 2,
  parameter int BW      = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NBANK-1:0]     req_valid,
  output logic [NBANK-1:0]     req_ready,
  input  logic [2*NBANK-1:0]   req_cmd,
  input  logic [AW*NBANK-1:0]  req_addr,
  output logic [NPHASE-1:0]    ph_valid,
  output logic [2*NPHASE-1:0]  ph_cmd,
  output logic [BW*NPHASE-1:0] ph_bank,
  output logic [AW*NPHASE-1:0] ph_addr
);
  localparam int CW = 8;
  localparam int RW = $clog2(MAX_RUN + 1) + 1;

  logic          dir;
  logic [CW-1:0] wtr_cnt, rtw_cnt;
  logic [RW-1:0] run_cnt;
  logic [BW-1:0] rr;

  logic pend_rd, pend_wr;
  always_comb begin
    pend_rd = 1'b0;
    pend_wr = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      if (req_valid[i] && req_cmd[2*i+1]) begin
        if (req_cmd[2*i]) pend_wr = 1'b1;
        else              pend_rd = 1'b1;
      end
    end
  end

  wire cur_pend = dir ? pend_wr : pend_rd;
  wire oth_pend = dir ? pend_rd : pend_wr;
  wire run_full = run_cnt >= RW'(MAX_RUN);
  wire col_open = (dir ? (rtw_cnt == '0) : (wtr_cnt == '0)) && !(run_full && oth_pend);
  wire do_switch = oth_pend && (!cur_pend || run_full);

  logic [NPHASE-1:0]    n_valid;
  logic [2*NPHASE-1:0]  n_cmd;
  logic [BW*NPHASE-1:0] n_bank;
  logic [AW*NPHASE-1:0] n_addr;
  logic                 row_used, rd_iss, wr_iss;
  int                   slots, last;

  always_comb begin
    req_ready = '0;
    n_valid   = '0;
    n_cmd     = '0;
    n_bank    = '0;
    n_addr    = '0;
    row_used  = 1'b0;
    rd_iss    = 1'b0;
    wr_iss    = 1'b0;
    slots     = 0;
    last      = int'(rr);
    for (int i = 0; i < NBANK; i++) begin
      int  idx;
      logic [1:0] c;
      logic ok;
      idx = (int'(rr) + i) % NBANK;
      c   = req_cmd[2*idx +: 2];
      ok  = req_valid[idx] && (!c[1] ? !row_used : (col_open && (c[0] == dir)));
      if (ok && slots < NPHASE) begin
        req_ready[idx]          = 1'b1;
        n_valid[slots]          = 1'b1;
        n_cmd[2*slots +: 2]     = c;
        n_bank[BW*slots +: BW]  = BW'(idx);
        n_addr[AW*slots +: AW]  = req_addr[AW*idx +: AW];
        if (!c[1])     row_used = 1'b1;
        else if (c[0]) wr_iss   = 1'b1;
        else           rd_iss   = 1'b1;
        slots = slots + 1;
        last  = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir      <= 1'b0;
      wtr_cnt  <= '0;
      rtw_cnt  <= '0;
      run_cnt  <= '0;
      rr       <= '0;
      ph_valid <= '0;
      ph_cmd   <= '0;
      ph_bank  <= '0;
      ph_addr  <= '0;
    end else begin
      ph_valid <= n_valid;
      ph_cmd   <= n_cmd;
      ph_bank  <= n_bank;
      ph_addr  <= n_addr;
      if (|req_ready) rr <= BW'((last + 1) % NBANK);
      wtr_cnt <= wr_iss ? CW'(T_WTR) : ((wtr_cnt != '0) ? wtr_cnt - 1'b1 : '0);
      rtw_cnt <= rd_iss ? CW'(T_RTW) : ((rtw_cnt != '0) ? rtw_cnt - 1'b1 : '0);
      if (do_switch) begin
        dir     <= ~dir;
        run_cnt <= '0;
      end else if ((rd_iss || wr_iss) && !run_full) begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_cmd_steer_chk.sv
module dram_cmd_steer_chk #(
  parameter int NBANK  = 4,
  parameter int NPHASE = 2,
  parameter int T_WTR  = 3,
  parameter int T_RTW  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NBANK-1:0]    req_valid,
  input logic [NBANK-1:0]    req_ready,
  input logic [NPHASE-1:0]   ph_valid,
  input logic [2*NPHASE-1:0] ph_cmd
);
  logic out_rd, out_wr;
  int   out_rows;
  always_comb begin
    out_rd = 1'b0;
    out_wr = 1'b0;
    out_rows = 0;
    for (int s = 0; s < NPHASE; s++) begin
      if (ph_valid[s]) begin
        if (!ph_cmd[2*s+1])   out_rows = out_rows + 1;
        else if (ph_cmd[2*s]) out_wr = 1'b1;
        else                  out_rd = 1'b1;
      end
    end
  end

  logic [7:0] since_wr, since_rd;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_wr <= 8'hFF;
      since_rd <= 8'hFF;
    end else begin
      since_wr <= out_wr ? 8'd0 : ((since_wr != 8'hFF) ? since_wr + 8'd1 : since_wr);
      since_rd <= out_rd ? 8'd0 : ((since_rd != 8'hFF) ? since_rd + 8'd1 : since_rd);
    end
  end

  p_ready_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  p_grant_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_ready) <= NPHASE);
  p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_rd && out_wr));
  p_wtr_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_rd |-> since_wr >= 8'(T_WTR));
  p_rtw_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> since_rd >= 8'(T_RTW));
  p_one_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_rows <= 1);
  p_reg_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> (|ph_valid));
endmodule

bind dram_cmd_steer dram_cmd_steer_chk #(
  .NBANK(NBANK), .NPHASE(NPHASE), .T_WTR(T_WTR), .T_RTW(T_RTW)
) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ph_valid(ph_valid), .ph_cmd(ph_cmd)
);

// File: tb/dram_cmd_steer_test.sv
module dram_cmd_steer_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] req_valid = '0;
  logic [3:0] req_ready;
  logic [7:0] req_cmd = '0;
  logic [31:0] req_addr = {8'h13, 8'h12, 8'h11, 8'h10};
  logic [1:0] ph_valid;
  logic [3:0] ph_cmd;
  logic [3:0] ph_bank;
  logic [15:0] ph_addr;
  int tests = 0, fails = 0;
  bit done = 0;

  dram_cmd_steer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .ph_valid(ph_valid),
    .ph_cmd(ph_cmd), .ph_bank(ph_bank), .ph_addr(ph_addr)
  );

  always #2 clk = ~clk;

  // {valid, cmd, expected ready}; each vector is applied right after reset
  localparam logic [15:0] VEC [8] = '{
    {4'hF, 8'hAA, 4'h3}, {4'hF, 8'hEB, 4'h6}, {4'hF, 8'hFF, 4'h0},
    {4'hF, 8'hA1, 4'h5}, {4'hF, 8'h55, 4'h1}, {4'hE, 8'h8C, 4'hC},
    {4'h0, 8'h00, 4'h0}, {4'h8, 8'h80, 4'h8}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    req_valid = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic drive(logic [3:0] v, logic [7:0] c);
    req_valid = v;
    req_cmd = c;
    #1;
  endtask

  task automatic next();
    @(negedge clk);
    #1;
  endtask

  initial begin
    do_reset();
    #1;
    check("R10 slot valid after reset", 32'(ph_valid), 0);
    check("R10 ready after reset", 32'(req_ready), 0);

    for (int k = 0; k < 8; k++) begin
      do_reset();
      drive(VEC[k][15:12], VEC[k][11:4]);
      check($sformatf("R1 R2 R3 R8 vector %0d", k), 32'(req_ready), 32'(VEC[k][3:0]));
    end

    // R9: registered slot contents, scan order
    do_reset();
    drive(4'hF, 8'hAA);
    next();
    check("R9 slot valid", 32'(ph_valid), 32'h3);
    check("R9 slot cmd", 32'(ph_cmd), 32'hA);
    check("R9 slot bank", 32'(ph_bank), 32'h4);
    check("R9 slot addr", 32'(ph_addr), 32'h1110);
    do_reset();
    drive(4'hE, 8'h8C);
    next();
    check("R9 R8 mixed slot cmd", 32'(ph_cmd), 32'h8);
    check("R9 R8 mixed slot bank", 32'(ph_bank), 32'hE);
    drive(4'h0, 8'h00);
    next();
    check("R9 empty slots", {28'd0, ph_cmd, ph_valid}, 0);

    // R4 and R6: switch to write, then back to read with write-to-read gap
    do_reset();
    drive(4'hF, 8'hFF);
    check("R4 switch cycle grants nothing", 32'(req_ready), 0);
    next();
    check("R6 writes after switch", 32'(req_ready), 32'h3);
    next();
    drive(4'hF, 8'hAA);
    check("R4 write-to-read switch cycle", 32'(req_ready), 0);
    check("R9 write slots out", {28'd0, ph_cmd}, 32'hF);
    next();
    check("R6 read held (1)", 32'(req_ready), 0);
    next();
    check("R6 read held (2)", 32'(req_ready), 0);
    next();
    check("R6 read after gap", 32'(req_ready), 32'hC);

    // R7: read-to-write turnaround
    do_reset();
    drive(4'hF, 8'hAA);
    check("R7 initial reads", 32'(req_ready), 32'h3);
    next();
    drive(4'hF, 8'hFF);
    check("R7 switch cycle", 32'(req_ready), 0);
    next();
    check("R7 write held", 32'(req_ready), 0);
    next();
    check("R7 write after gap", 32'(req_ready), 32'hC);

    // R5 and R2: run limit with a write waiting
    do_reset();
    drive(4'hF, 8'hAE);
    check("R5 run cycle 1", 32'(req_ready), 32'h5);
    next();
    check("R2 pointer wraps", 32'(req_ready), 32'h9);
    next();
    check("R5 run limit stops reads", 32'(req_ready), 0);
    next();
    check("R5 R7 turnaround after limit", 32'(req_ready), 0);
    next();
    check("R5 waiting write granted", 32'(req_ready), 32'h2);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule